// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the scan timing for a display pipeline. It holds a horizontal pixel counter and a vertical line counter. From them it produces registered strobes: an active-display enable, a blanking flag, and horizontal and vertical sync. It also outputs the current pixel and line coordinates, so a downstream pixel pipeline can fetch and place data.

Software configures the block through a small address/data register port. Each axis has three timing registers. Each register packs two boundaries, and each boundary is stored as its value minus one. A control bit starts and stops the scan. A lock register guards every configuration write, so software must write a key before it can change anything. The usual sequence is: unlock, clear the enable, program the six timing words, set the enable, relock.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the block is locked, the enable is clear, every timing register reads 0, both coordinates are 0, blank is 1, and de, hsync and vsync are 0.
- R2: A write to address 0 with the value 32'h0000_5A3C unlocks the block. A write of any other value to address 0 locks it. Address 0 reads 1 when unlocked and 0 when locked.
- R3: While the block is locked, writes to addresses 1 to 7 leave the stored contents unchanged.
- R4: Reads return the stored value one cycle after the address is presented, whatever the lock state. Address 2 holds horizontal active/total, 3 horizontal blank, 4 horizontal sync, 5 vertical active/total, 6 vertical blank and 7 vertical sync.
- R5: Address 1 bit 0 is the scan enable. All other bits of address 1 read 0.
- R6: In each timing register, bits 15:0 hold the first boundary minus one and bits 31:16 hold the second boundary minus one.
- R7: While enabled, pix_x counts up by one per clock. It returns to 0 on the clock after it equals or exceeds the horizontal total-minus-one field.
- R8: line_y changes only when pix_x returns to 0. It counts up by one per line and returns to 0 after it equals or exceeds the vertical total-minus-one field.
- R9: de is 1 exactly when pix_x is at most the horizontal active-minus-one field and line_y is at most the vertical active-minus-one field.
- R10: blank is 1 when either coordinate is greater than its blank-start field and at most its blank-end field.
- R11: hsync is 1 when pix_x is greater than the horizontal sync-start field and at most the sync-end field. vsync applies the same rule to line_y. Both are active high.
- R12: One clock after the enable reads clear, both coordinates are 0, blank is 1, and de, hsync and vsync are 0.
- R13: All strobes are registered and, in each cycle, agree with the pix_x and line_y shown in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| pix_x | output | 12 | Current pixel coordinate |
| line_y | output | 12 | Current line coordinate |
| de | output | 1 | Active-display enable |
| blank | output | 1 | Blanking flag |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The hardest part to reach from the ports is the interaction of both axes: the vertical wrap, and the corners where vertical blank or sync overlaps horizontal regions. A full-size mode would need hundreds of thousands of cycles to cover these. The bench therefore programs a tiny mode, 10 pixels by 7 lines, and follows three whole frames cycle by cycle against a coordinate model. That run crosses every region boundary and several vertical wraps. The lock is exercised by register vectors: writes before unlock, unlock, a wrong key that relocks, and a timing write rejected while relocked.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int ADDR_W  = 3;
    localparam int REG_W   = 32;
    localparam int FIELD_W = 16;
    localparam int N_AXES  = 2;
    localparam int N_KINDS = 3;

    localparam logic [ADDR_W-1:0] RA_LOCK = 3'd0;
    localparam logic [ADDR_W-1:0] RA_CTRL = 3'd1;
    localparam int                RA_TIM0 = 2;

    localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_5A3C;

    // kind index inside an axis: 0 active/total, 1 blank, 2 sync
    localparam int K_ACT = 0;
    localparam int K_BLK = 1;
    localparam int K_SYN = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } pair_t;

    typedef pair_t [N_KINDS-1:0] axis_cfg_t;

    typedef struct packed {
        logic active;
        logic blank;
        logic sync;
    } axis_flags_t;

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output logic                     unlocked,
    output logic                     enable,
    output axis_cfg_t [N_AXES-1:0]   cfg
);

    typedef struct packed {
        logic                   unlocked;
        logic                   enable;
        axis_cfg_t [N_AXES-1:0] cfg;
        logic [REG_W-1:0]       rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // write side: lock register is always writable
        if (we) begin
            if (addr == RA_LOCK) begin
                st_d.unlocked = (wdata == UNLOCK_KEY);
            end else if (st_q.unlocked) begin
                if (addr == RA_CTRL) begin
                    st_d.enable = wdata[0];
                end
                for (int a = 0; a < N_AXES; a++) begin
                    for (int k = 0; k < N_KINDS; k++) begin
                        if (addr == ADDR_W'(RA_TIM0 + N_KINDS * a + k)) begin
                            st_d.cfg[a][k] = wdata;
                        end
                    end
                end
            end
        end

        // read side: stored values, independent of lock
        st_d.rdata = '0;
        if (addr == RA_LOCK) begin
            st_d.rdata = {{(REG_W-1){1'b0}}, st_q.unlocked};
        end else if (addr == RA_CTRL) begin
            st_d.rdata = {{(REG_W-1){1'b0}}, st_q.enable};
        end
        for (int a = 0; a < N_AXES; a++) begin
            for (int k = 0; k < N_KINDS; k++) begin
                if (addr == ADDR_W'(RA_TIM0 + N_KINDS * a + k)) begin
                    st_d.rdata = st_q.cfg[a][k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign unlocked = st_q.unlocked;
    assign enable   = st_q.enable;
    assign cfg      = st_q.cfg;

endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic               enable,
    input  logic [CNT_W-1:0]   h_cur,
    input  logic [CNT_W-1:0]   v_cur,
    input  logic [FIELD_W-1:0] h_tot_m1,
    input  logic [FIELD_W-1:0] v_tot_m1,
    output logic [CNT_W-1:0]   h_nxt,
    output logic [CNT_W-1:0]   v_nxt
);

    logic h_end;
    logic v_end;

    always_comb begin
        h_end = FIELD_W'(h_cur) >= h_tot_m1;
        v_end = FIELD_W'(v_cur) >= v_tot_m1;
        if (!enable) begin
            h_nxt = '0;
            v_nxt = '0;
        end else if (h_end) begin
            h_nxt = '0;
            v_nxt = v_end ? '0 : v_cur + 1'b1;
        end else begin
            h_nxt = h_cur + 1'b1;
            v_nxt = v_cur;
        end
    end

endmodule

// File: rtl/rtg_window.sv
module rtg_window
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [FIELD_W-1:0] act_m1,
    input  pair_t              blk,
    input  pair_t              syn,
    output axis_flags_t        flags
);

    logic [FIELD_W-1:0] c;

    always_comb begin
        c            = FIELD_W'(cnt);
        flags.active = c <= act_m1;
        flags.blank  = (c > blk.lo) && (c <= blk.hi);
        flags.sync   = (c > syn.lo) && (c <= syn.hi);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              de,
    output logic              blank,
    output logic              hsync,
    output logic              vsync
);

    localparam int AX_H = 0;
    localparam int AX_V = 1;

    typedef struct packed {
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
        logic             de;
        logic             blank;
        logic             hsync;
        logic             vsync;
    } scan_state_t;

    scan_state_t st_d, st_q;

    logic                   en;
    logic                   unlocked;
    axis_cfg_t [N_AXES-1:0] cfg_all;
    logic [CNT_W-1:0]       cnt_cur [N_AXES];
    logic [CNT_W-1:0]       cnt_nxt [N_AXES];
    axis_flags_t            flg     [N_AXES];

    rtg_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .unlocked (unlocked),
        .enable   (en),
        .cfg      (cfg_all)
    );

    assign cnt_cur[AX_H] = st_q.h;
    assign cnt_cur[AX_V] = st_q.v;

    rtg_scan #(.CNT_W(CNT_W)) u_scan (
        .enable   (en),
        .h_cur    (cnt_cur[AX_H]),
        .v_cur    (cnt_cur[AX_V]),
        .h_tot_m1 (cfg_all[AX_H][K_ACT].hi),
        .v_tot_m1 (cfg_all[AX_V][K_ACT].hi),
        .h_nxt    (cnt_nxt[AX_H]),
        .v_nxt    (cnt_nxt[AX_V])
    );

    // decode on the next counts so strobes line up with the registered coordinates
    for (genvar ax = 0; ax < N_AXES; ax++) begin : g_axis
        rtg_window #(.CNT_W(CNT_W)) u_win (
            .cnt    (cnt_nxt[ax]),
            .act_m1 (cfg_all[ax][K_ACT].lo),
            .blk    (cfg_all[ax][K_BLK]),
            .syn    (cfg_all[ax][K_SYN]),
            .flags  (flg[ax])
        );
    end

    always_comb begin
        st_d   = st_q;
        st_d.h = cnt_nxt[AX_H];
        st_d.v = cnt_nxt[AX_V];
        if (en) begin
            st_d.de    = flg[AX_H].active & flg[AX_V].active;
            st_d.blank = flg[AX_H].blank  | flg[AX_V].blank;
            st_d.hsync = flg[AX_H].sync;
            st_d.vsync = flg[AX_V].sync;
        end else begin
            st_d.de    = 1'b0;
            st_d.blank = 1'b1;
            st_d.hsync = 1'b0;
            st_d.vsync = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_x  = st_q.h;
    assign line_y = st_q.v;
    assign de     = st_q.de;
    assign blank  = st_q.blank;
    assign hsync  = st_q.hsync;
    assign vsync  = st_q.vsync;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_addr,
    input  logic [31:0]            cfg_wdata,
    input  logic                   unlocked,
    input  logic                   enable,
    input  axis_cfg_t [N_AXES-1:0] cfg,
    input  logic [CNT_W-1:0]       pix_x,
    input  logic [CNT_W-1:0]       line_y,
    input  logic                   de,
    input  logic                   blank,
    input  logic                   hsync,
    input  logic                   vsync
);

    assert_lock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == RA_LOCK) |=> (unlocked == ($past(cfg_wdata) == UNLOCK_KEY)));

    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !unlocked && cfg_addr != RA_LOCK) |=> ($stable(cfg) && $stable(enable)));

    assert_hstep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ((pix_x == $past(pix_x) + 1'b1) || (pix_x == '0)));

    assert_vstep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_y) |-> (pix_x == '0));

    assert_de_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> $past(enable));

    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pix_x == '0 && line_y == '0 && blank && !de && !hsync && !vsync));

endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .unlocked  (unlocked),
    .enable    (en),
    .cfg       (cfg_all),
    .pix_x     (pix_x),
    .line_y    (line_y),
    .de        (de),
    .blank     (blank),
    .hsync     (hsync),
    .vsync     (vsync)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int CNT_W = 12;
    localparam logic [31:0] KEY = 32'h0000_5A3C;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic [CNT_W-1:0] pix_x;
    logic [CNT_W-1:0] line_y;
    logic             de, blank, hsync, vsync;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;  // 125 MHz

    raster_timing_gen #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_x(pix_x),
        .line_y(line_y), .de(de), .blank(blank), .hsync(hsync), .vsync(vsync)
    );

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // write addr/wd, then read addr back and expect exp
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 32'h0000_0001, 32'h0000_0000, 4'd3},  // R3 locked ctrl write dropped
        '{3'd2, 32'h1234_5678, 32'h0000_0000, 4'd3},  // R3 locked timing write dropped
        '{3'd0, KEY,           32'h0000_0001, 4'd2},  // R2 key unlocks
        '{3'd1, 32'hFFFF_FFFF, 32'h0000_0001, 4'd5},  // R5 only bit 0 kept
        '{3'd1, 32'h0000_0000, 32'h0000_0000, 4'd5},  // R5 clear
        '{3'd2, 32'h0009_0003, 32'h0009_0003, 4'd4},  // R4 h act 4 / tot 10
        '{3'd3, 32'h0009_0003, 32'h0009_0003, 4'd4},  // R4 h blank 4..10
        '{3'd4, 32'h0008_0005, 32'h0008_0005, 4'd6},  // R6 h sync 6..9
        '{3'd5, 32'h0006_0002, 32'h0006_0002, 4'd4},  // R4 v act 3 / tot 7
        '{3'd6, 32'h0006_0002, 32'h0006_0002, 4'd4},  // R4 v blank 3..7
        '{3'd7, 32'h0005_0003, 32'h0005_0003, 4'd6},  // R6 v sync 4..6
        '{3'd0, 32'h0000_0001, 32'h0000_0000, 4'd2},  // R2 wrong value relocks
        '{3'd4, 32'hDEAD_BEEF, 32'h0008_0005, 4'd3},  // R3 relocked write dropped
        '{3'd0, KEY,           32'h0000_0001, 4'd2}   // R2 unlock again
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    initial begin
        logic [31:0] r;
        int eh, ev;
        bit synced;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pix_x == 0 && line_y == 0, 1, "coords after reset", {pix_x, line_y}, 0);
        check(blank && !de && !hsync && !vsync, 1, "strobes after reset",
              {blank, de, hsync, vsync}, 32'h8);
        rd(3'd0, r); check(r == 0, 1, "lock after reset", r, 0);
        rd(3'd5, r); check(r == 0, 1, "timing reg after reset", r, 0);

        // register vectors (R2..R6)
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].wd);
            rd(VEC[i].addr, r);
            check(r == VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d readback", i),
                  r, VEC[i].exp);
        end

        // R12 still idle while disabled
        check(pix_x == 0 && line_y == 0 && blank, 12, "idle before enable",
              {pix_x, line_y, 7'd0, blank}, 1);

        // scan run: R7 R8 R9 R10 R11 R13
        wr(3'd1, 32'h1);
        synced = 1'b0;
        for (int i = 0; i < 20 && !synced; i++) begin
            @(negedge clk);
            if (pix_x == 1) synced = 1'b1;
        end
        check(synced, 7, "counter start", {31'd0, synced}, 1);
        eh = 1; ev = 0;
        for (int c = 0; c < 210; c++) begin
            if (c != 0) @(negedge clk);
            check(pix_x == CNT_W'(eh), 7, "pix_x", 32'(pix_x), eh);
            check(line_y == CNT_W'(ev), 8, "line_y", 32'(line_y), ev);
            check(de == (eh <= 3 && ev <= 2), 9, "de", 32'(de), 32'(eh <= 3 && ev <= 2));
            check(blank == ((eh > 3 && eh <= 9) || (ev > 2 && ev <= 6)), 10, "blank",
                  32'(blank), 32'((eh > 3 && eh <= 9) || (ev > 2 && ev <= 6)));
            check(hsync == (eh > 5 && eh <= 8), 11, "hsync", 32'(hsync), 32'(eh > 5 && eh <= 8));
            check(vsync == (ev > 3 && ev <= 5), 11, "vsync R13", 32'(vsync),
                  32'(ev > 3 && ev <= 5));
            if (eh >= 9) begin
                eh = 0;
                ev = (ev >= 6) ? 0 : ev + 1;
            end else begin
                eh = eh + 1;
            end
        end

        // R12 disable forces idle
        wr(3'd1, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(pix_x == 0 && line_y == 0, 12, "coords when disabled",
                  {pix_x, line_y}, 0);
            check(blank && !de && !hsync && !vsync, 12, "strobes when disabled",
                  {blank, de, hsync, vsync}, 32'h8);
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog expired: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule